// File: doc/BRIEF.md
# Configuration Bus Width and Sync Aligner

This block sits at the front of a configuration loader and watches the incoming configuration data bus from reset onward. In parallel mode it first works out how many data lanes the external source drives. It does this by looking for a fixed two-byte marker on the lowest byte lane: a marker byte followed by a code byte that names the width. Once the width is locked, it reassembles the incoming bytes into a byte stream. It then searches that stream, at every byte offset, for a 32-bit synchronisation word.

After the synchronisation word is found, every later byte is packed most-significant-byte first into aligned 32-bit words. Each word is handed on with a one-cycle valid strobe. Nothing is passed on before that point. In serial mode, the upstream has already assembled full 32-bit words. The width marker is not acted on, and the synchronisation search runs from reset. A watchdog counts clock cycles from reset until synchronisation and raises a sticky timeout flag when its limit runs out.

Top module: `cfg_bus_aligner`

## Requirements
- R1: While rst_ni is low, width_o, width_lock_o, sync_o, timeout_o, word_o and word_vld_o are all zero, and width search restarts from its idle state.
- R2: In parallel mode (par_mode_i=1), a valid beat with 0xBB in data_i[7:0] followed by the next valid beat with 0x11, 0x22 or 0x44 in data_i[7:0] sets width_lock_o and sets width_o to 0 (8-bit), 1 (16-bit) or 2 (32-bit). Both take effect at the rising edge that samples the code beat.
- R3: After 0xBB, a code byte other than the three width codes returns the search to looking for 0xBB. A repeated 0xBB counts as a fresh marker. Beats with vld_i low, upper byte lanes, and filler bytes such as 0xFF and 0x00 never advance the search.
- R4: Once locked, width_lock_o and width_o hold until reset, whatever marker patterns follow.
- R5: In parallel mode, the synchronisation search covers only beats that arrive after the lock beat. A synchronisation word sent earlier is not recognised.
- R6: Beats form a byte stream in this order: at 32-bit width data_i[31:24], [23:16], [15:8], then [7:0]; at 16-bit width data_i[15:8] then [7:0]; at 8-bit width data_i[7:0]. sync_o rises at the edge that samples the beat holding the last byte of the sequence 0xAA,0x99,0x55,0x66, at any byte offset and across beat boundaries. It stays high until reset.
- R7: No word is output before synchronisation. After it, the bytes that follow the synchronisation word are packed MSB-first into 32-bit words. word_vld_o pulses for one cycle, with word_o holding the word, at the edge that samples the beat completing that word.
- R8: In serial mode (par_mode_i=0), width markers are ignored, width_lock_o stays low, every valid beat carries four bytes in 32-bit order, and the synchronisation search runs from reset.
- R9: If sync_o is still low, timeout_o rises at the TMO_CYCLES-th rising edge after reset release and stays high until reset. If synchronisation is found first, timeout_o never rises.
- R10: A TMO_CYCLES setting below 513 (0x201) behaves as a limit of 513.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| par_mode_i | input | 1 | 1 = parallel bus with width detection, 0 = serial (pre-assembled words); static after reset |
| vld_i | input | 1 | data_i carries a beat this cycle |
| data_i | input | 32 | Configuration data bus |
| width_o | output | 2 | Detected width code: 0 = 8, 1 = 16, 2 = 32 bits |
| width_lock_o | output | 1 | Width detection complete |
| sync_o | output | 1 | Synchronisation word found |
| timeout_o | output | 1 | Watchdog expired before synchronisation |
| word_o | output | 32 | Aligned data word |
| word_vld_o | output | 1 | word_o valid for this cycle |

## Verification
Every result is registered. width_o and width_lock_o respond to a code beat at the first rising edge after it is driven. sync_o responds the same way to the beat holding the last synchronisation byte, and word_o with word_vld_o to the beat completing a word. The bench drives each beat at a falling edge and samples 5 ns after the following rising edge, so each beat's expected result is compared in exactly the cycle it is due. timeout_o is checked one edge before and exactly at its limit, counting rising edges from the falling edge at which reset is released.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

  typedef enum logic [1:0] {
    BW_8  = 2'd0,
    BW_16 = 2'd1,
    BW_32 = 2'd2
  } bus_w_e;

  localparam logic [7:0]  MARK_BYTE = 8'hBB;
  localparam logic [7:0]  CODE_W8   = 8'h11;
  localparam logic [7:0]  CODE_W16  = 8'h22;
  localparam logic [7:0]  CODE_W32  = 8'h44;
  localparam logic [31:0] SYNC_WORD = 32'hAA99_5566;
  localparam int unsigned TMO_MIN   = 513;

  function automatic logic [2:0] lane_bytes(bus_w_e w);
    case (w)
      BW_8:    return 3'd1;
      BW_16:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/bwd_width_fsm.sv
module bwd_width_fsm
  import bwd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       vld_i,
  input  logic [7:0] lane_i,
  output bus_w_e     width_o,
  output logic       lock_o
);

  typedef enum logic [1:0] {S_SEEK, S_MARK, S_DONE} st_e;

  st_e    st_q;
  bus_w_e width_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_SEEK;
      width_q <= BW_8;
    end else if (en_i && vld_i) begin
      unique case (st_q)
        S_SEEK: if (lane_i == MARK_BYTE) st_q <= S_MARK;
        S_MARK: begin
          if (lane_i == CODE_W8) begin
            width_q <= BW_8;
            st_q    <= S_DONE;
          end else if (lane_i == CODE_W16) begin
            width_q <= BW_16;
            st_q    <= S_DONE;
          end else if (lane_i == CODE_W32) begin
            width_q <= BW_32;
            st_q    <= S_DONE;
          end else if (lane_i != MARK_BYTE) begin
            st_q <= S_SEEK;
          end
        end
        default: ;
      endcase
    end
  end

  assign width_o = width_q;
  assign lock_o  = (st_q == S_DONE);

  // R4: lock and width never change once set
  a_r4_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lock_o) |-> (lock_o && $stable(width_o)));

  // R2: lock only follows a sampled beat in parallel mode
  a_r2_lock_on_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(en_i && vld_i));

endmodule

// File: rtl/bwd_sync_align.sv
module bwd_sync_align
  import bwd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        run_i,
  input  logic        vld_i,
  input  logic [2:0]  nb_i,     // bytes in this beat: 1, 2 or 4
  input  logic [31:0] data_i,   // bytes left-justified, unused low bytes zero
  output logic        sync_o,
  output logic [31:0] word_o,
  output logic        word_vld_o
);

  localparam int unsigned HIST_W = 24;
  localparam int unsigned BUF_W  = 56;

  logic [HIST_W-1:0] hist_q;
  logic [BUF_W-1:0]  buf_q;
  logic [2:0]        fill_q;
  logic              sync_q;
  logic [31:0]       word_q;
  logic              wv_q;

  logic [BUF_W-1:0]  ext;
  logic [BUF_W-1:0]  ext_sh;
  logic [5:0]        hist_sh;
  logic [HIST_W-1:0] hist_nxt;
  logic [3:0]        hit;
  logic              hit_any;
  logic [1:0]        hit_idx;
  logic [2:0]        skip;
  logic [BUF_W-1:0]  ins;
  logic [BUF_W-1:0]  merged;
  logic [3:0]        sum;

  assign ext      = {hist_q, data_i};
  assign hist_sh  = 6'd32 - {nb_i, 3'b000};
  assign ext_sh   = ext >> hist_sh;
  assign hist_nxt = ext_sh[HIST_W-1:0];

  // window ending at the j-th new byte
  for (genvar j = 0; j < 4; j++) begin : g_win
    assign hit[j] = (3'(j) < nb_i) && (ext[BUF_W-1-8*j -: 32] == SYNC_WORD);
  end

  always_comb begin
    hit_any = 1'b0;
    hit_idx = 2'd0;
    for (int j = 3; j >= 0; j--) begin
      if (hit[j]) begin
        hit_any = 1'b1;
        hit_idx = 2'(j);
      end
    end
  end

  assign skip   = {1'b0, hit_idx} + 3'd1;
  assign ins    = {data_i, 24'h0} >> {fill_q, 3'b000};
  assign merged = buf_q | ins;
  assign sum    = {1'b0, fill_q} + {1'b0, nb_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      buf_q  <= '0;
      fill_q <= '0;
      sync_q <= 1'b0;
      word_q <= '0;
      wv_q   <= 1'b0;
    end else begin
      wv_q <= 1'b0;
      if (run_i && vld_i) begin
        if (!sync_q) begin
          hist_q <= hist_nxt;
          if (hit_any) begin
            sync_q <= 1'b1;
            buf_q  <= {data_i, 24'h0} << {skip, 3'b000};
            fill_q <= nb_i - skip;
          end
        end else if (sum >= 4'd4) begin
          word_q <= merged[BUF_W-1 -: 32];
          wv_q   <= 1'b1;
          buf_q  <= merged << 32;
          fill_q <= 3'(sum - 4'd4);
        end else begin
          buf_q  <= merged;
          fill_q <= sum[2:0];
        end
      end
    end
  end

  assign sync_o     = sync_q;
  assign word_o     = word_q;
  assign word_vld_o = wv_q;

  // R6: sync flag is sticky
  a_r6_sync_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sync_q) |-> sync_q);

  // R7: no word before sync was already established
  a_r7_word_after_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wv_q |-> $past(sync_q));

  // R7: at most three bytes carried between beats
  a_r7_fill_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= 3'd3);

  // R5: search advances only on accepted beats
  a_r5_hist_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(run_i && vld_i) |-> $stable(hist_q));

endmodule

// File: rtl/bwd_watchdog.sv
module bwd_watchdog #(
  parameter int unsigned LIMIT = 65536
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_i,
  output logic tmo_o
);

  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic          tmo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else if (wait_i && !tmo_q) begin
      if (cnt_q == CW'(LIMIT - 1)) tmo_q <= 1'b1;
      else                         cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tmo_o = tmo_q;

  // R9: counter stays inside its window
  a_r9_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(LIMIT));

  // R9: timeout is sticky
  a_r9_tmo_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(tmo_q) |-> tmo_q);

endmodule

// File: rtl/cfg_bus_aligner.sv
module cfg_bus_aligner
  import bwd_pkg::*;
#(
  parameter int unsigned TMO_CYCLES = 65536
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        par_mode_i,
  input  logic        vld_i,
  input  logic [31:0] data_i,
  output logic [1:0]  width_o,
  output logic        width_lock_o,
  output logic        sync_o,
  output logic        timeout_o,
  output logic [31:0] word_o,
  output logic        word_vld_o
);

  localparam int unsigned TMO_EFF = (TMO_CYCLES < TMO_MIN) ? TMO_MIN : TMO_CYCLES;

  bus_w_e      width;
  logic        lock;
  logic        run;
  logic [2:0]  nb;
  logic [31:0] lj_data;

  bwd_width_fsm u_width (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (par_mode_i),
    .vld_i   (vld_i),
    .lane_i  (data_i[7:0]),
    .width_o (width),
    .lock_o  (lock)
  );

  always_comb begin
    if (!par_mode_i) begin
      nb      = 3'd4;
      lj_data = data_i;
    end else begin
      nb = lane_bytes(width);
      unique case (width)
        BW_8:    lj_data = {data_i[7:0], 24'h0};
        BW_16:   lj_data = {data_i[15:0], 16'h0};
        default: lj_data = data_i;
      endcase
    end
  end

  assign run = par_mode_i ? lock : 1'b1;

  bwd_sync_align u_align (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .vld_i      (vld_i),
    .nb_i       (nb),
    .data_i     (lj_data),
    .sync_o     (sync_o),
    .word_o     (word_o),
    .word_vld_o (word_vld_o)
  );

  bwd_watchdog #(.LIMIT(TMO_EFF)) u_wdog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wait_i (!sync_o),
    .tmo_o  (timeout_o)
  );

  assign width_o      = width;
  assign width_lock_o = par_mode_i & lock;

  // R5: in parallel mode sync implies a completed width lock
  a_r5_sync_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_mode_i && sync_o) |-> width_lock_o);

  // R8: serial mode never reports a width lock
  a_r8_serial_no_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_mode_i |-> !width_lock_o);

  // R9: timeout cannot rise after sync was already found
  a_r9_no_tmo_after_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> !$past(sync_o));

endmodule

// File: tb/tb_cfg_bus_aligner.sv
`timescale 1ns/1ps
module tb_cfg_bus_aligner;

  localparam int unsigned LIM    = 600;
  localparam int unsigned LIM_CL = 513;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        par_mode_i = 1'b1;
  logic        vld_i = 1'b0;
  logic [31:0] data_i = '0;
  logic [1:0]  width_o, c_width;
  logic        width_lock_o, sync_o, timeout_o, word_vld_o;
  logic        c_lock, c_sync, c_tmo, c_wv;
  logic [31:0] word_o, c_word;

  always #10 clk = ~clk;

  cfg_bus_aligner #(.TMO_CYCLES(LIM)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .par_mode_i(par_mode_i), .vld_i(vld_i),
    .data_i(data_i), .width_o(width_o), .width_lock_o(width_lock_o),
    .sync_o(sync_o), .timeout_o(timeout_o), .word_o(word_o), .word_vld_o(word_vld_o));

  cfg_bus_aligner #(.TMO_CYCLES(100)) dut_clamp (
    .clk_i(clk), .rst_ni(rst_ni), .par_mode_i(par_mode_i), .vld_i(1'b0),
    .data_i(32'h0), .width_o(c_width), .width_lock_o(c_lock),
    .sync_o(c_sync), .timeout_o(c_tmo), .word_o(c_word), .word_vld_o(c_wv));

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int cyc   = 0;

  // reference model state
  bit          m_par, m_lock, m_mark, m_sync;
  logic [1:0]  m_w;
  logic [31:0] m_last, m_acc;
  int          m_n;
  bit          exp_wv;
  logic [31:0] exp_w;
  byte unsigned sq[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      summary();
    end
  end

  function automatic int nbytes(bit par, logic [1:0] w);
    if (!par) return 4;
    return (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
  endfunction

  task automatic model_reset(input bit par);
    m_par = par; m_lock = 0; m_mark = 0; m_sync = 0; m_w = 0;
    m_last = 0; m_acc = 0; m_n = 0; exp_wv = 0; exp_w = 0;
  endtask

  task automatic model_byte(input logic [7:0] b);
    if (!m_sync) begin
      m_last = {m_last[23:0], b};
      if (m_last == 32'hAA995566) begin
        m_sync = 1; m_acc = 0; m_n = 0;
      end
    end else begin
      m_acc = {m_acc[23:0], b};
      m_n++;
      if (m_n == 4) begin
        exp_wv = 1; exp_w = m_acc; m_n = 0;
      end
    end
  endtask

  task automatic model_beat(input logic [31:0] d, input bit v);
    exp_wv = 0;
    if (!v) return;
    if (!m_par || m_lock) begin
      int n = nbytes(m_par, m_w);
      for (int i = 0; i < n; i++) begin
        logic [31:0] t = d >> (8 * (n - 1 - i));
        model_byte(t[7:0]);
      end
    end else begin
      logic [7:0] b = d[7:0];
      if (m_mark) begin
        if (b == 8'h11)      begin m_lock = 1; m_w = 0; end
        else if (b == 8'h22) begin m_lock = 1; m_w = 1; end
        else if (b == 8'h44) begin m_lock = 1; m_w = 2; end
        else if (b != 8'hBB) m_mark = 0;
        if (m_lock) m_last = 0;
      end else if (b == 8'hBB) m_mark = 1;
    end
  endtask

  // one beat: drive at falling edge, sample 5 ns after the rising edge
  task automatic apply(input logic [31:0] d, input bit v);
    data_i = d; vld_i = v;
    model_beat(d, v);
    @(posedge clk); #5;
    chk(word_vld_o == exp_wv, "R7 word_vld", 32'(word_vld_o), 32'(exp_wv));
    if (exp_wv) chk(word_o == exp_w, "R7 word", word_o, exp_w);
    chk(sync_o == m_sync, "R6 sync", 32'(sync_o), 32'(m_sync));
    chk(width_lock_o == m_lock, "R2 lock", 32'(width_lock_o), 32'(m_lock));
    if (m_lock) chk(width_o == m_w, "R2 width", 32'(width_o), 32'(m_w));
    @(negedge clk);
  endtask

  task automatic do_reset(input bit par);
    rst_ni = 0; par_mode_i = par; vld_i = 0; data_i = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    model_reset(par);
  endtask

  task automatic lane0(input logic [7:0] b);
    apply({$urandom() & 32'h00FF_FF00, 8'h00} | {24'h0, b}, 1'b1);
  endtask

  // send queued bytes packed into beats of the locked width
  task automatic send_q();
    int n = nbytes(m_par, m_w);
    while (sq.size() > 0) begin
      logic [31:0] d, p;
      if (($urandom() % 5) == 0) apply($urandom(), 1'b0);
      p = 0;
      for (int i = 0; i < n; i++) p = (p << 8) | 32'(sq.size() > 0 ? sq.pop_front() : 8'($urandom()));
      d = (n == 4) ? 32'h0 : ($urandom() << (8 * n));
      apply(d | p, 1'b1);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));

    // R1: reset values
    rst_ni = 0;
    repeat (2) @(negedge clk);
    chk({width_o, width_lock_o, sync_o, timeout_o, word_vld_o} == 0, "R1 flags", 32'({width_o, width_lock_o, sync_o, timeout_o, word_vld_o}), 0);
    chk(word_o == 0, "R1 word", word_o, 0);
    do_reset(1);
    chk(width_lock_o == 0 && sync_o == 0, "R1 after release", 32'({width_lock_o, sync_o}), 0);

    // R3: bad code, upper lane marker, idle beat, repeated marker
    lane0(8'hFF); lane0(8'h00); lane0(8'hBB); lane0(8'h33);
    chk(width_lock_o == 0, "R3 bad code", 32'(width_lock_o), 0);
    apply(32'h00BB_0000, 1); apply(32'h0000_0011, 1);
    chk(width_lock_o == 0, "R3 upper lane", 32'(width_lock_o), 0);
    // R5: sync word before lock is not seen
    lane0(8'hAA); lane0(8'h99); lane0(8'h55); lane0(8'h66);
    apply(32'hAA99_5566, 1);
    chk(sync_o == 0, "R5 early sync", 32'(sync_o), 0);
    lane0(8'hBB); apply(32'h0000_0033, 0); lane0(8'hBB); lane0(8'h22);
    chk(width_lock_o == 1 && width_o == 2'd1, "R3 relock 16", 32'({width_lock_o, width_o}), 32'h5);
    sq = '{8'h01, 8'hAA, 8'h99, 8'h55, 8'h66, 8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h00};
    send_q();
    chk(sync_o == 1, "R6 odd offset 16", 32'(sync_o), 1);

    // R4: width held after further markers
    do_reset(1);
    lane0(8'hBB); lane0(8'h11);
    lane0(8'hBB); lane0(8'h44);
    chk(width_o == 2'd0 && width_lock_o, "R4 width held", 32'(width_o), 0);
    sq = '{8'hAA, 8'h99, 8'h55, 8'h66, 8'h12, 8'h34, 8'h56, 8'h78};
    send_q();
    chk(sync_o == 1, "R6 sync w8", 32'(sync_o), 1);

    // R8: serial mode
    do_reset(0);
    apply(32'h0000_00BB, 1); apply(32'h0000_0044, 1);
    chk(width_lock_o == 0, "R8 marker ignored", 32'(width_lock_o), 0);
    apply(32'h11AA_9955, 1);
    apply(32'h6612_3456, 1);
    chk(sync_o == 1, "R8 sync direct", 32'(sync_o), 1);
    apply(32'h789A_BCDE, 1);
    chk(word_o == 32'h1234_5678, "R8 first word", word_o, 32'h1234_5678);

    // random runs for each width
    for (int it = 0; it < 24; it++) begin
      int w = it % 3;
      do_reset(1);
      for (int k = 0; k < int'($urandom() % 5); k++) begin
        if ($urandom() % 4 == 0) apply($urandom(), 0);
        lane0(($urandom() % 2) ? 8'hFF : 8'h00);
      end
      lane0(8'hBB);
      lane0(w == 0 ? 8'h11 : w == 1 ? 8'h22 : 8'h44);
      sq.delete();
      for (int k = 0; k < int'($urandom() % 10); k++) sq.push_back(8'($urandom()));
      sq.push_back(8'hAA); sq.push_back(8'h99); sq.push_back(8'h55); sq.push_back(8'h66);
      for (int k = 0; k < 8 + int'($urandom() % 24); k++) sq.push_back(8'($urandom()));
      send_q();
      chk(sync_o == 1, "R6 random sync", 32'(sync_o), 1);
    end

    // R9 / R10: watchdog limits
    do_reset(1);
    for (int k = 1; k <= 620; k++) begin
      apply($urandom(), 0);
      if (k == LIM - 1) chk(timeout_o == 0, "R9 before limit", 32'(timeout_o), 0);
      if (k == LIM)     chk(timeout_o == 1, "R9 at limit", 32'(timeout_o), 1);
      if (k == LIM_CL - 1) chk(c_tmo == 0, "R10 before min", 32'(c_tmo), 0);
      if (k == LIM_CL)     chk(c_tmo == 1, "R10 at min", 32'(c_tmo), 1);
    end
    chk(timeout_o == 1 && c_tmo == 1, "R9 sticky", 32'({timeout_o, c_tmo}), 32'h3);

    do_reset(0);
    apply(32'hAA99_5566, 1);
    for (int k = 0; k < 650; k++) apply($urandom(), 0);
    chk(timeout_o == 0, "R9 no timeout after sync", 32'(timeout_o), 0);

    done = 1'b1;
    summary();
  end

endmodule